// File: doc/BRIEF.md
# SPI Master Serial Clock and Select Timing Generator

This block produces the timing skeleton of an SPI master transfer: an active-low slave select, a mode-0 serial clock (idle low, data sampled on the rising edge), and one-cycle strobes that tell an external shift register when to sample and when to shift. It holds no data path. A data path built around it loads its first bit before the transfer begins. It captures a bit on each `sample_stb` and moves the next bit out on each `shift_stb`.

A transfer begins with a one-cycle `start` pulse while the block is idle. On that pulse the block captures four values: the clock divisor, the select-to-first-edge delay code, the last-edge-to-release delay code and the bit count. Later changes to these inputs have no effect until the next accepted start. One half-period counter paces the whole transfer. Its reload value is the divisor, with zero raised to one. The same counter measures the lead and lag delays, in half serial-clock units. `busy` covers the whole time select is low, and `done` marks the cycle in which select returns high.

Top module: `spi_sck_timer`

## Requirements
- R1: After reset and whenever idle: `ssel_n`=1, `sck`=0, `busy`=0, `done`=0, `sample_stb`=0, `shift_stb`=0.
- R2: Each serial clock half period lasts H = max(`div_cfg`,1) system clock cycles, so the clock is the system clock divided by 2·H. Codes 0 and 1 both divide by 2, code 2 divides by 4 and code 1023 divides by 2046.
- R3: `ssel_n` falls on the clock edge that samples an accepted `start`. The first rising `sck` edge follows L·H cycles later. For `lead_cfg` codes 0 and 1, L=1 (0.5 SCK). Code 2 gives L=2 (1.0 SCK) and code 3 gives L=3 (1.5 SCK).
- R4: A transfer has B = max(`nbits`,1) rising `sck` edges. `sample_stb` is high for exactly the one cycle in which `sck` has just become 1. `shift_stb` is high for exactly the one cycle in which `sck` has just become 0, and this includes the last falling edge. Neither strobe occurs at any other time.
- R5: `ssel_n` returns high G·H cycles after the last falling `sck` edge. G is decoded from `lag_cfg` in the same way L is decoded from `lead_cfg` (0,1→1; 2→2; 3→3).
- R6: `busy` equals the inverse of `ssel_n` in every cycle. `done` is high for one cycle, the cycle in which `ssel_n` has just returned high, and at no other time.
- R7: `div_cfg`, `lead_cfg`, `lag_cfg` and `nbits` are captured at the accepted start. Changes to them during a transfer do not alter its timing.
- R8: A `start` pulse seen while `busy` is high is ignored. It neither restarts nor extends the transfer, and no transfer follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_cfg | input | DIV_W (10) | Half-period length code |
| lead_cfg | input | DLY_W (2) | Select-to-first-edge delay code |
| lag_cfg | input | DLY_W (2) | Last-edge-to-release delay code |
| start | input | 1 | Transfer request, taken only when idle |
| nbits | input | NB_W (6) | Number of bits (0 acts as 1) |
| ssel_n | output | 1 | Active-low slave select |
| sck | output | 1 | Serial clock, idle low |
| sample_stb | output | 1 | One-cycle pulse with each rising sck edge |
| shift_stb | output | 1 | One-cycle pulse with each falling sck edge |
| busy | output | 1 | High while select is asserted |
| done | output | 1 | One-cycle pulse as select is released |

## Verification
A wrong reload value or a corrupted half-period count shows at the ports at the very next `sck` edge, as an edge that comes early or late. So the scoreboard times every edge in cycles from the fall of select, not only the final edge. A wrong lead or lag unit count moves the first rising edge or the release of select by whole multiples of H, and this is visible within the same transfer. A wrong edge count or phase shows as a missing or extra strobe, or as a `done` that is out of place, before the next transfer can start. Configuration and start inputs are disturbed in the middle of a transfer to show that the captured settings are really held.

// File: rtl/spi_tmg_pkg.sv
`timescale 1ns/1ps
package spi_tmg_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_XFER, PH_LAG} phase_e;

  // Reset contents of the captured configuration
  localparam int unsigned RST_DIV   = 2;
  localparam int unsigned RST_LEAD  = 1;
  localparam int unsigned RST_LAG   = 1;
  localparam int unsigned RST_NBITS = 8;

  // Divisor, delay code and bit count all raise zero to one
  function automatic int unsigned at_least_one(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

  // Clock edges still due after the first rising edge of a transfer
  function automatic int unsigned edges_after_first(input int unsigned bits);
    return 2 * bits - 1;
  endfunction

endpackage

// File: rtl/spi_tmg_halfcnt.sv
`timescale 1ns/1ps
module spi_tmg_halfcnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt;

  assign tick = run && !load && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= reload;
    else if (run)     cnt <= tick ? reload : cnt - W'(1);
  end
endmodule

// File: rtl/spi_tmg_cfg.sv
`timescale 1ns/1ps
module spi_tmg_cfg #(
  parameter int DIV_W = 10,
  parameter int DLY_W = 2,
  parameter int NB_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [DIV_W-1:0] div_in,
  input  logic [DLY_W-1:0] lead_in,
  input  logic [DLY_W-1:0] lag_in,
  input  logic [NB_W-1:0]  nb_in,
  output logic [DIV_W-1:0] div_cur,
  output logic [DLY_W-1:0] lead_cur,
  output logic [DLY_W-1:0] lag_cur,
  output logic [NB_W-1:0]  nb_cur
);
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] lead_q, lag_q;
  logic [NB_W-1:0]  nb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(spi_tmg_pkg::RST_DIV);
      lead_q <= DLY_W'(spi_tmg_pkg::RST_LEAD);
      lag_q  <= DLY_W'(spi_tmg_pkg::RST_LAG);
      nb_q   <= NB_W'(spi_tmg_pkg::RST_NBITS);
    end else if (capture) begin
      div_q  <= div_in;
      lead_q <= lead_in;
      lag_q  <= lag_in;
      nb_q   <= nb_in;
    end
  end

  // The capture cycle already uses the new values
  assign div_cur  = capture ? div_in  : div_q;
  assign lead_cur = capture ? lead_in : lead_q;
  assign lag_cur  = capture ? lag_in  : lag_q;
  assign nb_cur   = capture ? nb_in   : nb_q;
endmodule

// File: rtl/spi_tmg_seq.sv
`timescale 1ns/1ps
module spi_tmg_seq #(
  parameter int DLY_W = 2,
  parameter int NB_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             tick,
  input  logic [DLY_W-1:0] lead_u,
  input  logic [DLY_W-1:0] lag_u,
  input  logic [NB_W-1:0]  nbits,
  output logic             ssel_n,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             busy,
  output logic             done
);
  import spi_tmg_pkg::*;
  localparam int EW = NB_W + 1;

  phase_e           phase;
  logic [DLY_W-1:0] units;
  logic [EW-1:0]    edge_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      units      <= '0;
      edge_left  <= '0;
      ssel_n     <= 1'b1;
      sck        <= 1'b0;
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      shift_stb  <= 1'b0;
      done       <= 1'b0;
      unique case (phase)
        PH_IDLE: if (go) begin
          phase  <= PH_LEAD;
          units  <= lead_u;
          ssel_n <= 1'b0;
          busy   <= 1'b1;
          sck    <= 1'b0;
        end
        PH_LEAD: if (tick) begin
          if (units == DLY_W'(1)) begin
            phase      <= PH_XFER;
            sck        <= 1'b1;
            sample_stb <= 1'b1;
            edge_left  <= EW'(edges_after_first(32'(nbits)));
          end else begin
            units <= units - DLY_W'(1);
          end
        end
        PH_XFER: if (tick) begin
          sck        <= ~sck;
          sample_stb <= ~sck;
          shift_stb  <= sck;
          edge_left  <= edge_left - EW'(1);
          if (edge_left == EW'(1)) begin
            phase <= PH_LAG;
            units <= lag_u;
          end
        end
        PH_LAG: if (tick) begin
          if (units == DLY_W'(1)) begin
            phase  <= PH_IDLE;
            ssel_n <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b1;
          end else begin
            units <= units - DLY_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_timer.sv
`timescale 1ns/1ps
module spi_sck_timer #(
  parameter int DIV_W = 10,
  parameter int DLY_W = 2,
  parameter int NB_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [DLY_W-1:0] lead_cfg,
  input  logic [DLY_W-1:0] lag_cfg,
  input  logic             start,
  input  logic [NB_W-1:0]  nbits,
  output logic             ssel_n,
  output logic             sck,
  output logic             sample_stb,
  output logic             shift_stb,
  output logic             busy,
  output logic             done
);
  import spi_tmg_pkg::*;

  // Named internal events, also seen by the bound checker
  logic             go;
  logic             tick;
  logic [DIV_W-1:0] div_cur, half_len;
  logic [DLY_W-1:0] lead_cur, lag_cur, lead_units, lag_units;
  logic [NB_W-1:0]  nb_cur, nb_eff;

  assign go = start && !busy;

  spi_tmg_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .NB_W(NB_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(go),
    .div_in(div_cfg), .lead_in(lead_cfg), .lag_in(lag_cfg), .nb_in(nbits),
    .div_cur(div_cur), .lead_cur(lead_cur), .lag_cur(lag_cur), .nb_cur(nb_cur)
  );

  assign half_len   = DIV_W'(at_least_one(32'(div_cur)));
  assign lead_units = DLY_W'(at_least_one(32'(lead_cur)));
  assign lag_units  = DLY_W'(at_least_one(32'(lag_cur)));
  assign nb_eff     = NB_W'(at_least_one(32'(nb_cur)));

  spi_tmg_halfcnt #(.W(DIV_W)) u_half (
    .clk(clk), .rst_n(rst_n), .load(go), .run(busy),
    .reload(half_len), .tick(tick)
  );

  spi_tmg_seq #(.DLY_W(DLY_W), .NB_W(NB_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .tick(tick),
    .lead_u(lead_units), .lag_u(lag_units), .nbits(nb_eff),
    .ssel_n(ssel_n), .sck(sck), .sample_stb(sample_stb),
    .shift_stb(shift_stb), .busy(busy), .done(done)
  );
endmodule

// File: rtl/spi_sck_timer_chk.sv
`timescale 1ns/1ps
module spi_sck_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic go,
  input logic tick,
  input logic ssel_n,
  input logic sck,
  input logic sample_stb,
  input logic shift_stb,
  input logic busy,
  input logic done
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ssel_n && !sck && !sample_stb && !shift_stb));

  a_r2_sck_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck) |-> $past(tick));

  a_r3_select_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ssel_n) |-> $past(start) && $past(go));

  a_r4_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (sck && !$past(sck)));

  a_r4_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (!sck && $past(sck)));

  a_r6_busy_tracks_select: assert property (@(posedge clk) disable iff (!rst_n)
    busy != ssel_n);

  a_r6_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ssel_n && !$past(ssel_n)));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sample_stb, shift_stb, done}));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !$fell(ssel_n));
endmodule

bind spi_sck_timer spi_sck_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .go(go), .tick(tick),
  .ssel_n(ssel_n), .sck(sck), .sample_stb(sample_stb),
  .shift_stb(shift_stb), .busy(busy), .done(done)
);

// File: tb/spi_sck_timer_tb.sv
`timescale 1ns/1ps
module spi_sck_timer_tb;
  localparam int DIV_W = 10;
  localparam int DLY_W = 2;
  localparam int NB_W  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [DIV_W-1:0] div_cfg  = '0;
  logic [DLY_W-1:0] lead_cfg = '0;
  logic [DLY_W-1:0] lag_cfg  = '0;
  logic [NB_W-1:0]  nbits    = '0;
  logic             start    = 1'b0;
  logic ssel_n, sck, sample_stb, shift_stb, busy, done;

  spi_sck_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W), .NB_W(NB_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .div_cfg(div_cfg), .lead_cfg(lead_cfg),
    .lag_cfg(lag_cfg), .start(start), .nbits(nbits), .ssel_n(ssel_n),
    .sck(sck), .sample_stb(sample_stb), .shift_stb(shift_stb),
    .busy(busy), .done(done)
  );

  int checks = 0;
  int failures = 0;

  // Event kinds: 1 = sck rise, 2 = sck fall, 3 = select release
  typedef struct { int t; int kind; string req; } ev_t;
  ev_t expq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int raise0(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  // Driver side: predicted edge times, counted from the select fall
  task automatic push_expect(input int dv, input int ld, input int lg,
                             input int nb, input string tag);
    int h, l, g, b;
    ev_t e;
    h = raise0(dv); l = raise0(ld); g = raise0(lg); b = raise0(nb);
    for (int i = 0; i < 2 * b; i++) begin
      e.t = (l + i) * h;
      e.kind = (i % 2 == 0) ? 1 : 2;
      e.req = (tag != "") ? tag : ((i == 0) ? "R3" : "R2");
      expq.push_back(e);
    end
    e.t = (l + 2 * b - 1 + g) * h;
    e.kind = 3;
    e.req = (tag != "") ? tag : "R5";
    expq.push_back(e);
  endtask

  task automatic launch(input int dv, input int ld, input int lg,
                        input int nb, input string tag);
    while (busy) @(negedge clk);
    @(negedge clk);
    div_cfg = DIV_W'(dv); lead_cfg = DLY_W'(ld);
    lag_cfg = DLY_W'(lg); nbits = NB_W'(nb);
    push_expect(dv, ld, lg, nb, tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0 || busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: measures edges and compares them with the queue
  int  tcnt = 0;
  logic p_ssel = 1'b1;
  logic p_sck  = 1'b0;

  task automatic compare(input int kind);
    ev_t e;
    if (expq.size() == 0) begin
      check(1'b0, "R8", "unexpected event kind", kind, 0);
    end else begin
      e = expq.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      check(e.t == tcnt, e.req, "event time", tcnt, e.t);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ssel && !ssel_n) tcnt = 0;
      else tcnt++;
      if (sck != p_sck) begin
        if (sck) check(sample_stb && !shift_stb, "R4", "strobes on rise",
                       {sample_stb, shift_stb}, 2'b10);
        else     check(!sample_stb && shift_stb, "R4", "strobes on fall",
                       {sample_stb, shift_stb}, 2'b01);
        compare(sck ? 1 : 2);
      end else if (sample_stb || shift_stb) begin
        check(1'b0, "R4", "strobe without edge", {sample_stb, shift_stb}, 0);
      end
      if (!p_ssel && ssel_n) begin
        check(done && !busy, "R6", "done/busy at release", {done, busy}, 2'b10);
        compare(3);
      end else if (done) begin
        check(1'b0, "R6", "stray done", 1, 0);
      end
      if (busy == ssel_n) check(1'b0, "R6", "busy vs ssel_n", busy, !ssel_n);
      p_ssel = ssel_n;
      p_sck  = sck;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ssel_n && !sck && !busy && !done && !sample_stb && !shift_stb,
          "R1", "outputs in reset",
          {ssel_n, sck, busy, done, sample_stb, shift_stb}, 6'b100000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ssel_n && !sck && !busy && !done, "R1", "idle after reset",
          {ssel_n, sck, busy, done}, 4'b1000);

    launch(2, 1, 1, 8, "");      // divide by 4, default delays
    drain();
    launch(0, 0, 3, 3, "");      // code 0 divides by 2, long lag
    drain();
    launch(1, 2, 2, 1, "");      // code 1 divides by 2, single bit
    drain();
    launch(5, 3, 0, 4, "");      // lead 1.5 SCK, lag code 0
    drain();
    launch(1023, 1, 1, 1, "");   // largest divisor: divide by 2046
    drain();
    launch(3, 2, 1, 0, "R4");    // nbits 0 behaves as one bit
    drain();

    // R7: inputs change right after the start is taken
    launch(3, 1, 2, 2, "R7");
    div_cfg = 10'd7; lead_cfg = 2'd3; lag_cfg = 2'd3; nbits = 6'd5;
    drain();

    // R8: second start while busy is dropped
    launch(4, 2, 2, 3, "R8");
    repeat (20) @(negedge clk);
    div_cfg = 10'd1; nbits = 6'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    repeat (40) @(negedge clk);
    check(ssel_n && !busy && !sck, "R8", "idle after ignored start",
          {ssel_n, busy, sck}, 3'b100);
    check(expq.size() == 0, "R8", "pending events", expq.size(), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule